// File: doc/BRIEF.md
# Chained Presettable Binary Up-Counter

This block is a synchronous binary up-counter built from identical 4-bit counter stages joined into one wider count. Each stage has a rising-edge register with an asynchronous active-low clear, a synchronous active-low parallel load, and two count-enable inputs. The first is a plain count enable shared by every stage. The second is a carry-in enable, and it also gates that stage's combinational terminal-count flag.

The wrapper chains the stages by feeding each stage's terminal-count flag into the carry-in enable of the stage above it. The lowest stage's carry-in enable is the external carry enable. The load strobe, the load value and the plain count enable go to all stages together. The result behaves as one counter of STAGE_W*NUM_STAGES bits. Its carry-out can drive the carry enable of a further chain.

There is no data stream here, so every pin is a plain control or status pin and there is no handshake.

Top module: `chained_bin_counter`

## Requirements
- R1: While `clr_n` is low, `count` is all zeros at once, with no clock edge needed. This overrides the load strobe and both enables.
- R2: When `load_n` is low at a rising clock edge and `clr_n` is high, `count` takes the value of `load_val` after that edge. The levels of `cnt_en` and `carry_en` make no difference.
- R3: When `load_n` is high and both `cnt_en` and `carry_en` are high at a rising edge, `count` rises by exactly one, taken as an unsigned number of STAGE_W*NUM_STAGES bits.
- R4: When `load_n` is high and either `cnt_en` or `carry_en` is low at a rising edge, `count` keeps its value.
- R5: `carry_out` is 1 exactly when `carry_en` is 1 and every bit of `count` is 1. It is combinational: a change of `carry_en` shows on `carry_out` within the same clock period, with no edge between.
- R6: `cnt_en` has no effect on `carry_out`. With `count` all ones and `carry_en` high, `carry_out` stays 1 whether `cnt_en` is 0 or 1.
- R7: An increment from the all-ones value gives all zeros, so the counter steps through every state in binary order.
- R8: On an increment, stage k (bits k*STAGE_W up to k*STAGE_W+STAGE_W-1 of `count`) changes only when all bits below it are 1. A carry therefore crosses every stage boundary in the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load strobe, active low |
| cnt_en | input | 1 | Plain count enable, shared by all stages |
| carry_en | input | 1 | Carry-in enable of the lowest stage, also gates the carry-out |
| load_val | input | STAGE_W*NUM_STAGES | Value loaded when `load_n` is low |
| count | output | STAGE_W*NUM_STAGES | Current count |
| carry_out | output | 1 | High when `carry_en` is high and `count` is all ones |

## Verification
The bench targets the carry crossing between stages (0x0FF to 0x100, 0xEFF to 0xF00, all ones to zero). A stage whose carry-in came from the wrong place would advance early or stay behind. A clear is dropped into the middle of a clock period while the counter runs, and a clear that waited for the clock would still show the old count. Loads are applied with both enables low and also during counting, to catch a load that is wrongly gated by the enables. The carry enable is toggled between edges with the count at all ones and `cnt_en` low, which exposes a carry-out that is registered or that wrongly uses the plain count enable.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Action a counter stage takes at the next rising edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/cnt_action_dec.sv
module cnt_action_dec
  import cnt_pkg::*;
(
  input  logic     load_n,
  input  logic     cnt_en,
  input  logic     carry_in,
  output cnt_act_e act
);
  // Load wins over both enables; counting needs both enables high.
  always_comb begin
    if (!load_n)                act = ACT_LOAD;
    else if (cnt_en && carry_in) act = ACT_INC;
    else                        act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_term_det.sv
module cnt_term_det #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         carry_in,
  output logic         tc
);
  // Terminal count is gated by the carry-in only, never by the plain enable.
  assign tc = carry_in & (&q);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en,
  input  logic         carry_in,
  output logic [W-1:0] q,
  output logic         tc
);
  cnt_act_e     act;
  logic [W-1:0] q_nxt;

  cnt_action_dec u_dec (
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .act      (act)
  );

  always_comb begin
    unique case (act)
      ACT_LOAD: q_nxt = load_val;
      ACT_INC:  q_nxt = q + 1'b1;
      default:  q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  cnt_term_det #(.W(W)) u_tc (
    .q        (q),
    .carry_in (carry_in),
    .tc       (tc)
  );
endmodule

// File: rtl/chained_bin_counter.sv
module chained_bin_counter #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 3
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          cnt_en,
  input  logic                          carry_en,
  input  logic [STAGE_W*NUM_STAGES-1:0] load_val,
  output logic [STAGE_W*NUM_STAGES-1:0] count,
  output logic                          carry_out
);
  localparam int TOTAL_W = STAGE_W * NUM_STAGES;

  // carry_link[k] is the carry-in of stage k; carry_link[NUM_STAGES] leaves the chain.
  logic [NUM_STAGES:0] carry_link;

  assign carry_link[0] = carry_en;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .load_val (load_val[k*STAGE_W +: STAGE_W]),
      .cnt_en   (cnt_en),
      .carry_in (carry_link[k]),
      .q        (count[k*STAGE_W +: STAGE_W]),
      .tc       (carry_link[k+1])
    );
  end

  assign carry_out = carry_link[NUM_STAGES];

  initial begin
    if (TOTAL_W < 1) $error("chained_bin_counter: total width must be positive");
  end
endmodule

// File: rtl/chained_bin_counter_chk.sv
module chained_bin_counter_chk #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 3
) (
  input logic                          clk,
  input logic                          clr_n,
  input logic                          load_n,
  input logic                          cnt_en,
  input logic                          carry_en,
  input logic [STAGE_W*NUM_STAGES-1:0] load_val,
  input logic [STAGE_W*NUM_STAGES-1:0] count,
  input logic                          carry_out
);
  localparam int TW = STAGE_W * NUM_STAGES;

  always @(negedge clk) begin
    // R1
    if (!clr_n) clear_zero_chk: assert (count == '0);
    // R5
    carry_out_chk: assert (carry_out == (carry_en && (&count)));
  end

  // R2
  load_val_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(load_val));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en) |=> count == TW'($past(count) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_en)) |=> $stable(count));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en && (&count)) |=> count == '0);

  for (genvar k = 1; k < NUM_STAGES; k++) begin : g_bound
    // R8
    stage_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cnt_en && carry_en && !(&count[k*STAGE_W-1:0]))
        |=> $stable(count[k*STAGE_W +: STAGE_W]));
  end
endmodule

bind chained_bin_counter chained_bin_counter_chk #(
  .STAGE_W    (STAGE_W),
  .NUM_STAGES (NUM_STAGES)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .carry_en  (carry_en),
  .load_val  (load_val),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/sim_chained_bin_counter.sv
`timescale 1ns/1ps
module sim_chained_bin_counter;
  localparam int SW  = 4;
  localparam int NS  = 3;
  localparam int TW  = SW * NS;
  localparam int MOD = 1 << TW;

  logic          clk = 1'b0;
  logic          clr_n = 1'b0;
  logic          load_n = 1'b1;
  logic          cnt_en = 1'b0;
  logic          carry_en = 1'b0;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] count;
  logic          carry_out;

  int    n_vec = 0;
  int    n_bad = 0;
  int    m = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  chained_bin_counter #(.STAGE_W(SW), .NUM_STAGES(NS)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .load_val(load_val), .count(count), .carry_out(carry_out)
  );

  // Behavioural reference: one integer, updated per the requirements.
  always @(posedge clk or negedge clr_n) begin
    if (!clr_n)                 m <= 0;
    else if (!load_n)           m <= int'(load_val);
    else if (cnt_en && carry_en) m <= (m + 1) % MOD;
  end

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Every falling edge: compare against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      check({tag, " count"}, int'(count), m);
      check({tag, " carry"}, int'(carry_out), int'(carry_en && (m == MOD - 1)));
    end
  end

  // Apply inputs (called at posedge+1), then wait for the edge that uses them.
  task automatic cyc(input logic ld_n, input logic ce, input logic cy,
                     input logic [TW-1:0] v, input string t);
    load_n = ld_n; cnt_en = ce; carry_en = cy; load_val = v; tag = t;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
    end
  end

  initial begin
    // Reset state (R1)
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", int'(count), 0);
    check("R5 reset carry", int'(carry_out), 0);
    clr_n = 1'b1;
    cmp_on = 1'b1;

    // Load 12 then count 13..18 across the first boundary (R2, R3, R8)
    cyc(1'b0, 1'b1, 1'b1, 12'h00C, "R2");
    check("R2 load 0x00C", int'(count), 12'h00C);
    for (int i = 1; i <= 6; i++) begin
      cyc(1'b1, 1'b1, 1'b1, 12'h000, "R3");
      check("R3 step", int'(count), 12 + i);
    end
    check("R8 stage1 took carry", int'(count[7:4]), 1);
    // Drop an enable: hold (R4)
    cyc(1'b1, 1'b0, 1'b1, 12'h000, "R4");
    check("R4 hold cnt_en low", int'(count), 12'h012);
    cyc(1'b1, 1'b1, 1'b0, 12'h000, "R4");
    check("R4 hold carry_en low", int'(count), 12'h012);

    // Load with both enables low (R2)
    cyc(1'b0, 1'b0, 1'b0, 12'hABC, "R2");
    check("R2 load enables low", int'(count), 12'hABC);

    // Reach all ones, then carry behaviour (R5, R6)
    cyc(1'b0, 1'b0, 1'b1, 12'hFFE, "R2");
    cyc(1'b1, 1'b1, 1'b1, 12'h000, "R3");
    check("R3 to all ones", int'(count), 12'hFFF);
    cnt_en = 1'b0; tag = "R6";
    #0.5 check("R6 carry with cnt_en low", int'(carry_out), 1);
    carry_en = 1'b0;
    #0.5 check("R5 carry follows carry_en low", int'(carry_out), 0);
    carry_en = 1'b1;
    #0.5 check("R5 carry follows carry_en high", int'(carry_out), 1);
    @(posedge clk); #1;
    check("R4 held at all ones", int'(count), 12'hFFF);
    cyc(1'b1, 1'b1, 1'b1, 12'h000, "R7");
    check("R7 wrap to zero", int'(count), 0);
    check("R5 carry low after wrap", int'(carry_out), 0);

    // Boundary crossings (R8)
    cyc(1'b0, 1'b0, 1'b0, 12'h0FF, "R8");
    cyc(1'b1, 1'b1, 1'b1, 12'h000, "R8");
    check("R8 0x0FF to 0x100", int'(count), 12'h100);
    cyc(1'b0, 1'b1, 1'b1, 12'hEFF, "R8");
    cyc(1'b1, 1'b1, 1'b1, 12'h000, "R8");
    check("R8 0xEFF to 0xF00", int'(count), 12'hF00);

    // Load while counting wins (R2)
    cyc(1'b0, 1'b1, 1'b1, 12'h123, "R2");
    check("R2 load over count", int'(count), 12'h123);

    // Clear in the middle of a period (R1)
    cyc(1'b1, 1'b1, 1'b1, 12'h000, "R3");
    tag = "R1";
    clr_n = 1'b0;
    #0.5 check("R1 async clear", int'(count), 0);
    cyc(1'b0, 1'b1, 1'b1, 12'h777, "R1");
    check("R1 clear beats load", int'(count), 0);
    clr_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 12'h000, "R3");
    check("R3 count after clear", int'(count), 1);

    // Mixed run against the model (R2, R3, R4, R7, R8)
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 15);
      logic [TW-1:0] v = TW'($urandom) | 12'hF00;
      if (r == 0)      cyc(1'b0, r[0], r[1], v, "R2");
      else if (r < 3)  cyc(1'b1, 1'b0, 1'b1, v, "R4");
      else if (r == 3) cyc(1'b1, 1'b1, 1'b0, v, "R4");
      else             cyc(1'b1, 1'b1, 1'b1, v, "R3");
    end

    finish_run();
  end
endmodule